// File: doc/BRIEF.md
# Software-Loaded Translation Lookaside Buffer

This block is a small fully associative translation cache that maps virtual page numbers to physical frame numbers. Every entry holds a virtual page, a frame and three flag bits (valid, read allowed, write allowed). A lookup compares the page number of the request against every valid entry in parallel. One clock later it returns either the translated physical address, or a trap with a cause code.

The hardware never refills itself. When a lookup misses, or hits an entry whose flags forbid the access, the block raises a trap and records the faulting virtual page. Trap-handling software then works out the mapping, writes it into an entry slot of its own choosing through the load port, and replays the access. A flush input drops every mapping in one cycle, for example on a context switch.

Top module: `swtlb`

## Requirements
- R1: After reset, rsp_valid, rsp_trap and fault_vpn are zero and every entry is invalid, so the first lookup misses.
- R2: A lookup presented with req_valid high in one cycle produces rsp_valid high in the next cycle. rsp_valid is low in the cycle after a cycle with no request.
- R3: A permitted hit returns rsp_trap=0, rsp_cause=0, and rsp_paddr equal to the entry's frame number concatenated above the request's 12-bit page offset.
- R4: A lookup that matches no valid entry returns rsp_trap=1, rsp_cause=1 (miss) and rsp_paddr=0.
- R5: A read (req_write=0) requires the entry's read bit, and a write (req_write=1) requires its write bit. A failed check returns rsp_trap=1, rsp_cause=2 (permission) and rsp_paddr=0.
- R6: Each trapping lookup loads fault_vpn with the request's virtual page number. Each non-trapping lookup clears it to zero. In cycles with no lookup it holds its value.
- R7: A load writes the entry at ld_index in one cycle, and a lookup in any later cycle sees it. A lookup issued in the same cycle as the load sees the previous contents of that entry.
- R8: A load with ld_valid=0 invalidates its entry, so lookups of that page no longer match it.
- R9: When several valid entries hold the same virtual page, the lowest-numbered entry supplies the frame and the flags.
- R10: flush clears every valid bit in one cycle. A load in the same cycle still takes effect at its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address (page number above a 12-bit offset) |
| req_write | input | 1 | 1 = store access, 0 = load access |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 32 | Translated physical address, zero on a trap |
| rsp_trap | output | 1 | Lookup failed and software must intervene |
| rsp_cause | output | 2 | 0 none, 1 miss, 2 permission |
| fault_vpn | output | 20 | Virtual page of the most recent trapping lookup |
| ld_en | input | 1 | Entry write strobe |
| ld_index | input | 3 | Entry slot to write |
| ld_valid | input | 1 | Valid bit written into the slot |
| ld_vpn | input | 20 | Virtual page written into the slot |
| ld_pfn | input | 20 | Frame number written into the slot |
| ld_rd | input | 1 | Read permission written into the slot |
| ld_wr | input | 1 | Write permission written into the slot |
| flush | input | 1 | Invalidate all entries |

## Verification
The assertions assume that the control inputs are known (never X) whenever reset is released. They also assume that the offset bits of req_vaddr are meaningful only in cycles where req_valid is high. The flush property assumes that a lookup in the cycle after a flush saw no load in the flush cycle, so it constrains only that case. The directed tests drive every input on the falling edge and return all strobes to zero between scenarios. Loads and flushes are separated from lookups, except in the two scenarios that deliberately overlap them to exercise the ordering rules.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MISS = 2'd1,
    CAUSE_PERM = 2'd2
  } tlb_cause_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } tlb_perm_t;

endpackage

// File: rtl/swtlb_store.sv
module swtlb_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               flush,
  input  logic                               ld_en,
  input  logic [IDX_W-1:0]                   ld_index,
  input  logic                               ld_valid,
  input  logic [VPN_W-1:0]                   ld_vpn,
  input  logic [PFN_W-1:0]                   ld_pfn,
  input  swtlb_pkg::tlb_perm_t               ld_perm,
  output logic [ENTRIES-1:0]                 ent_valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]      ent_vpn,
  output logic [ENTRIES-1:0][PFN_W-1:0]      ent_pfn,
  output swtlb_pkg::tlb_perm_t [ENTRIES-1:0] ent_perm
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    logic valid_d;

    assign sel = ld_en && (ld_index == IDX_W'(e));

    always_comb begin
      valid_d = ent_valid[e];
      if (flush) valid_d = 1'b0;
      if (sel)   valid_d = ld_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_valid[e] <= 1'b0;
      else        ent_valid[e] <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_vpn[e]  <= ld_vpn;
        ent_pfn[e]  <= ld_pfn;
        ent_perm[e] <= ld_perm;
      end
    end
  end

endmodule

// File: rtl/swtlb_match.sv
module swtlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
  input  logic [VPN_W-1:0]              look_vpn,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);

  logic [ENTRIES-1:0] eq;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign eq[e] = ent_valid[e] && (ent_vpn[e] == look_vpn);
  end

  // scan from the top down so the lowest matching slot is assigned last
  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (eq[e]) hit_idx = IDX_W'(e);
    end
  end

endmodule

// File: rtl/swtlb.sv
module swtlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VPN_W+OFF_W-1:0] req_vaddr,
  input  logic                   req_write,
  output logic                   rsp_valid,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic                   rsp_trap,
  output logic [1:0]             rsp_cause,
  output logic [VPN_W-1:0]       fault_vpn,
  input  logic                   ld_en,
  input  logic [IDX_W-1:0]       ld_index,
  input  logic                   ld_valid,
  input  logic [VPN_W-1:0]       ld_vpn,
  input  logic [PFN_W-1:0]       ld_pfn,
  input  logic                   ld_rd,
  input  logic                   ld_wr,
  input  logic                   flush
);
  import swtlb_pkg::*;

  localparam int PA_W = PFN_W + OFF_W;

  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn;
  tlb_perm_t [ENTRIES-1:0]       ent_perm;
  tlb_perm_t                     ld_perm;

  logic [VPN_W-1:0] look_vpn;
  logic [OFF_W-1:0] look_off;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  tlb_perm_t        hit_perm;
  logic             allowed;

  logic             rsp_valid_d;
  logic [PA_W-1:0]  rsp_paddr_d;
  tlb_cause_e       cause_d, cause_q;
  logic [VPN_W-1:0] fault_vpn_d;

  assign ld_perm  = '{rd: ld_rd, wr: ld_wr};
  assign look_vpn = req_vaddr[VPN_W+OFF_W-1:OFF_W];
  assign look_off = req_vaddr[OFF_W-1:0];

  swtlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .ld_en     (ld_en),
    .ld_index  (ld_index),
    .ld_valid  (ld_valid),
    .ld_vpn    (ld_vpn),
    .ld_pfn    (ld_pfn),
    .ld_perm   (ld_perm),
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_pfn   (ent_pfn),
    .ent_perm  (ent_perm)
  );

  swtlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .look_vpn  (look_vpn),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  assign hit_perm = ent_perm[hit_idx];
  assign allowed  = req_write ? hit_perm.wr : hit_perm.rd;

  // next-state
  always_comb begin
    rsp_valid_d = req_valid;
    rsp_paddr_d = '0;
    cause_d     = CAUSE_NONE;
    fault_vpn_d = fault_vpn;
    if (req_valid) begin
      if (!hit) begin
        cause_d     = CAUSE_MISS;
        fault_vpn_d = look_vpn;
      end else if (!allowed) begin
        cause_d     = CAUSE_PERM;
        fault_vpn_d = look_vpn;
      end else begin
        rsp_paddr_d = {ent_pfn[hit_idx], look_off};
        fault_vpn_d = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      cause_q   <= CAUSE_NONE;
      fault_vpn <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (req_valid || rsp_valid) begin
        rsp_paddr <= rsp_paddr_d;
        cause_q   <= cause_d;
      end
      if (req_valid) fault_vpn <= fault_vpn_d;
    end
  end

  assign rsp_cause = cause_q;
  assign rsp_trap  = (cause_q != CAUSE_NONE);

endmodule

// File: rtl/swtlb_chk.sv
module swtlb_chk #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [VPN_W+OFF_W-1:0] req_vaddr,
  input logic                   req_write,
  input logic                   rsp_valid,
  input logic [PFN_W+OFF_W-1:0] rsp_paddr,
  input logic                   rsp_trap,
  input logic [1:0]             rsp_cause,
  input logic [VPN_W-1:0]       fault_vpn,
  input logic                   ld_en,
  input logic [IDX_W-1:0]       ld_index,
  input logic                   ld_valid,
  input logic [VPN_W-1:0]       ld_vpn,
  input logic [PFN_W-1:0]       ld_pfn,
  input logic                   ld_rd,
  input logic                   ld_wr,
  input logic                   flush
);

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r3_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_trap || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  a_r4_trap_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap |-> rsp_paddr == '0 && (rsp_cause == 2'd1 || rsp_cause == 2'd2));

  a_r6_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_trap || fault_vpn == $past(req_vaddr[VPN_W+OFF_W-1:OFF_W])));

  a_r6_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(fault_vpn));

  a_r10_flush_misses: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !ld_en |=> (req_valid |=> rsp_trap && rsp_cause == 2'd1));

endmodule

bind swtlb swtlb_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/swtlb_test.sv
module swtlb_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_trap;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic [19:0] fault_vpn;
  logic        ld_en, ld_valid, ld_rd, ld_wr, flush;
  logic [2:0]  ld_index;
  logic [19:0] ld_vpn, ld_pfn;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swtlb uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; req_vaddr = '0;
    ld_en = 0; ld_valid = 0; ld_rd = 0; ld_wr = 0; ld_index = '0;
    ld_vpn = '0; ld_pfn = '0; flush = 0;
  endtask

  task automatic load(input int idx, input bit v, input logic [19:0] vpn,
                      input logic [19:0] pfn, input bit r, input bit w);
    @(negedge clk);
    ld_en = 1; ld_index = idx[2:0]; ld_valid = v; ld_vpn = vpn;
    ld_pfn = pfn; ld_rd = r; ld_wr = w;
    @(negedge clk);
    ld_en = 0;
  endtask

  // issue one lookup and compare the response sampled at the next falling edge
  task automatic lookup(input logic [31:0] va, input bit wr, input logic [1:0] ecause,
                        input logic [31:0] epa, input string req);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid == 1'b1, {req, "/R2 valid"}, 64'(rsp_valid), 64'd1);
    check(rsp_cause == ecause, {req, " cause"}, 64'(rsp_cause), 64'(ecause));
    check(rsp_trap == (ecause != 2'd0), {req, " trap"}, 64'(rsp_trap), 64'(ecause != 2'd0));
    check(rsp_paddr == epa, {req, " paddr"}, 64'(rsp_paddr), 64'(epa));
    check(fault_vpn == ((ecause != 2'd0) ? va[31:12] : 20'd0), {req, "/R6 fault_vpn"},
          64'(fault_vpn), 64'((ecause != 2'd0) ? va[31:12] : 20'd0));
  endtask

  task automatic t_reset();
    check(rsp_valid == 0 && rsp_trap == 0 && fault_vpn == 0, "R1 reset outputs",
          64'({rsp_valid, rsp_trap, fault_vpn}), 64'd0);
    lookup(32'h12345_678, 0, 2'd1, 32'h0, "R1 empty miss");
  endtask

  task automatic t_retry();
    lookup(32'h12345_678, 0, 2'd1, 32'h0, "R4 miss");
    load(0, 1, 20'h12345, 20'hABCDE, 1, 1);
    lookup(32'h12345_678, 0, 2'd0, 32'hABCDE_678, "R3 retry hit");
    lookup(32'h12345_FFF, 1, 2'd0, 32'hABCDE_FFF, "R3 write hit");
  endtask

  task automatic t_hold();
    lookup(32'h00777_010, 0, 2'd1, 32'h0, "R4 second miss");
    repeat (3) @(negedge clk);
    check(fault_vpn == 20'h00777, "R6 hold idle", 64'(fault_vpn), 64'h777);
    check(rsp_valid == 0, "R2 idle no rsp", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_perm();
    load(3, 1, 20'h00040, 20'h00999, 1, 0);
    load(4, 1, 20'h00050, 20'h00888, 0, 1);
    lookup(32'h00040_004, 0, 2'd0, 32'h00999_004, "R5 read ok");
    lookup(32'h00040_004, 1, 2'd2, 32'h0, "R5 write denied");
    lookup(32'h00050_008, 0, 2'd2, 32'h0, "R5 read denied");
    lookup(32'h00050_008, 1, 2'd0, 32'h00888_008, "R5 write ok");
  endtask

  task automatic t_prio();
    load(5, 1, 20'h0AAAA, 20'h55555, 1, 1);
    load(2, 1, 20'h0AAAA, 20'h22222, 1, 1);
    lookup(32'h0AAAA_100, 0, 2'd0, 32'h22222_100, "R9 lowest wins");
    load(2, 0, 20'h0AAAA, 20'h22222, 1, 1);
    lookup(32'h0AAAA_100, 0, 2'd0, 32'h55555_100, "R8 invalidated slot");
    load(5, 0, 20'h0AAAA, 20'h55555, 1, 1);
    lookup(32'h0AAAA_100, 0, 2'd1, 32'h0, "R8 all gone");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    ld_en = 1; ld_index = 3'd6; ld_valid = 1; ld_vpn = 20'h0BBBB; ld_pfn = 20'h0F0F0;
    ld_rd = 1; ld_wr = 1;
    req_valid = 1; req_vaddr = 32'h0BBBB_020; req_write = 0;
    @(negedge clk);
    ld_en = 0; req_valid = 0;
    check(rsp_trap == 1 && rsp_cause == 2'd1, "R7 same-cycle sees old",
          64'(rsp_cause), 64'd1);
    lookup(32'h0BBBB_020, 0, 2'd0, 32'h0F0F0_020, "R7 later sees new");
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1;
    ld_en = 1; ld_index = 3'd7; ld_valid = 1; ld_vpn = 20'h0CCCC; ld_pfn = 20'h01234;
    ld_rd = 1; ld_wr = 0;
    @(negedge clk);
    flush = 0; ld_en = 0;
    lookup(32'h12345_678, 0, 2'd1, 32'h0, "R10 flushed entry");
    lookup(32'h00040_004, 0, 2'd1, 32'h0, "R10 flushed entry 3");
    lookup(32'h0CCCC_ABC, 0, 2'd0, 32'h01234_ABC, "R10 load survives flush");
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_retry();
    t_hold();
    t_perm();
    t_prio();
    t_same_cycle();
    t_flush();
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule